// File: doc/BRIEF.md
# Reset-Synchronized Three-Phase PWM Generator

This block is a timer that produces three-phase pulse-width modulation from a single up-counter. The counter advances on cycles where an external prescaler asserts its clock-enable. When the counter reaches the cycle-length register it returns to zero, and each of these wraps starts a new PWM cycle. Each phase has its own compare register. A phase turns active at every wrap and turns inactive when the counter reaches that phase's compare value.

Every phase drives a positive pin and a complementary negative pin. A seventh pin can toggle once per PWM cycle. The positive group and the negative group each have their own polarity bit, and every pin has its own output enable. Software sets everything up through a small write port while the timer is halted, then sets the start bit. Setup writes made while the timer runs are discarded, so the waveform cannot be disturbed in the middle of a cycle.

Top module: `pwm3_rsync_top`

## Requirements
- R1: While running, the counter (`count_o`) advances by one only on cycles with `ce_i` high. On a `ce_i` cycle where it equals the cycle-length register, it returns to 0 (a wrap). At reset every register is 0.
- R2: The write port decodes addresses as follows: 0 is control (bit 0 is the start bit, always writable), 1 is configuration, 2 is cycle length, and 3, 4 and 5 are the compare values of phases 0, 1 and 2. Writes to addresses 1 to 5 are ignored while `running_o` is 1. `running_o` shows the start bit.
- R3: When a phase's compare value is below the cycle length, its internal state becomes active at each wrap. It becomes inactive on a `ce_i` cycle where the counter equals the compare value. While halted the state is held active, so the first cycle begins active.
- R4: Each negative pin carries the inverse of its phase state, with the negative polarity applied.
- R5: A phase whose compare value equals the cycle length inverts its state at each wrap and otherwise holds it.
- R6: The toggle state is 0 while halted and inverts at each wrap. `tog_o` shows it only when configuration bit 2 (toggle enable) and bit 3 (toggle pin enable) are both set.
- R7: Configuration bit 0 is the active level of the positive pins and of `tog_o`. Configuration bit 1 is the active level of the negative pins. An inactive pin drives the inverse of its group's level.
- R8: Configuration bits 6:4 enable the positive pins of phases 2..0, and bits 9:7 enable the negative pins. A disabled pin drives its inactive level.
- R9: While halted, the counter is held at 0 and every pin drives its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Prescaler clock-enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| running_o | output | 1 | Timer running status |
| count_o | output | 16 | Counter value |
| pos_o | output | 3 | Positive-phase pins |
| neg_o | output | 3 | Negative-phase pins |
| tog_o | output | 1 | Cycle-synchronized toggle pin |

## Verification
A directed run uses a cycle length of 4 with compare values 1, 2 and 4. This separates a normal duty pulse from the toggle behaviour that applies when a compare value equals the cycle length. Cycle length 0 and compare value 0 test the wrap and the compare match when they land on the same count. A write of a new cycle length in the middle of a run shows whether the lock holds, because the wrap points would move if it did not. Random rounds vary the configuration, the polarity, the enables and a sparse clock-enable, and compare every pin in every cycle with a model built from the requirements. This separates gating errors, polarity errors and enable errors from one another.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int NUM_PH  = 3;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd3;

    localparam int CFG_W = 4 + 2*NUM_PH;

    typedef struct packed {
        logic [NUM_PH-1:0] oe_neg;   // bits 9:7
        logic [NUM_PH-1:0] oe_pos;   // bits 6:4
        logic              oe_tog;   // bit 3
        logic              tog_en;   // bit 2
        logic              lvl_neg;  // bit 1
        logic              lvl_pos;  // bit 0
    } cfg_t;

    function automatic logic drive_lvl(input logic act, input logic lvl);
        return act ? lvl : ~lvl;
    endfunction
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    output logic                          run,
    output cfg_t                          cfg,
    output logic [CNT_W-1:0]              len,
    output logic [NUM_PH-1:0][CNT_W-1:0]  cmp
);
    logic setup_ok;
    assign setup_ok = wr_en && !run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cfg <= '0;
            len <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) run <= wr_data[0];
            if (setup_ok && wr_addr == A_CFG) cfg <= cfg_t'(wr_data[CFG_W-1:0]);
            if (setup_ok && wr_addr == A_LEN) len <= wr_data;
        end
    end

    for (genvar i = 0; i < NUM_PH; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) cmp[i] <= '0;
            else if (setup_ok && wr_addr == A_CMP0 + ADDR_W'(i)) cmp[i] <= wr_data;
        end
    end

    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(len)); // R2
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(cfg)); // R2
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ce,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = run && ce && (cnt == len);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (wrap)    cnt <= '0;
        else if (ce)      cnt <= cnt + 1'b1;
    end

    AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
        (run && !ce) |=> $stable(cnt)); // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run && ce && cnt == len) |=> (cnt == '0)); // R1
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R9
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ce,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] cmp,
    output logic             act
);
    logic flip_mode;
    assign flip_mode = (cmp == len);

    always_ff @(posedge clk) begin
        if (rst || !run)               act <= 1'b1;
        else if (wrap)                 act <= flip_mode ? ~act : 1'b1;
        else if (ce && cnt == cmp)     act <= 1'b0;
    end

    AST_CMP_DROPS: assert property (@(posedge clk) disable iff (rst)
        (run && ce && cnt == cmp && cmp != len) |=> !act); // R3
    AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (rst)
        (wrap && cmp != len) |=> act); // R3
    AST_FLIP: assert property (@(posedge clk) disable iff (rst)
        (wrap && cmp == len) |=> (act != $past(act))); // R5
endmodule

// File: rtl/pwm3_rsync_top.sv
module pwm3_rsync_top
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic              running_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_PH-1:0] pos_o,
    output logic [NUM_PH-1:0] neg_o,
    output logic              tog_o
);
    logic                         run;
    cfg_t                         cfg;
    logic [CNT_W-1:0]             len;
    logic [NUM_PH-1:0][CNT_W-1:0] cmp;
    logic [CNT_W-1:0]             cnt;
    logic                         wrap;
    logic [NUM_PH-1:0]            act;
    logic                         tog_q;

    pwm3_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .run(run), .cfg(cfg), .len(len), .cmp(cmp)
    );

    pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .ce(ce_i), .len(len),
        .cnt(cnt), .wrap(wrap)
    );

    for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
        pwm3_phase #(.CNT_W(CNT_W)) u_ph (
            .clk(clk), .rst(rst), .run(run), .ce(ce_i), .wrap(wrap),
            .cnt(cnt), .len(len), .cmp(cmp[i]), .act(act[i])
        );
        assign pos_o[i] = drive_lvl(run && cfg.oe_pos[i] && act[i],  cfg.lvl_pos);
        assign neg_o[i] = drive_lvl(run && cfg.oe_neg[i] && !act[i], cfg.lvl_neg);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) tog_q <= 1'b0;
        else if (wrap)   tog_q <= ~tog_q;
    end

    assign tog_o     = drive_lvl(run && cfg.tog_en && cfg.oe_tog && tog_q, cfg.lvl_pos);
    assign running_o = run;
    assign count_o   = cnt;

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
        (run && wrap) |=> (tog_q != $past(tog_q))); // R6
    AST_TOG_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tog_q); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt <= len)); // R1
endmodule

// File: tb/sim_pwm3_rsync_top.sv
module sim_pwm3_rsync_top;
    localparam int W = 16;

    logic clk = 0, rst = 1, ce = 0, we = 0;
    logic [2:0] addr = 0;
    logic [W-1:0] data = 0;
    logic running;
    logic [W-1:0] count;
    logic [2:0] pos, neg;
    logic tog;

    always #5 clk = ~clk;

    pwm3_rsync_top #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .ce_i(ce), .wr_en_i(we), .wr_addr_i(addr),
        .wr_data_i(data), .running_o(running), .count_o(count),
        .pos_o(pos), .neg_o(neg), .tog_o(tog)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    bit         m_run;
    bit [9:0]   m_cfg;
    bit [W-1:0] m_len, m_cnt;
    bit [W-1:0] m_cmp [3];
    bit [2:0]   m_act;
    bit         m_tog;

    function automatic bit lvl(bit a, bit l);
        return a ? l : !l;
    endfunction

    task automatic chk(string req, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act_v, exp_v, $time);
        end
    endtask

    task automatic compare_all();
        bit [2:0] ep, en;
        bit et;
        for (int i = 0; i < 3; i++) begin
            ep[i] = lvl(m_run && m_cfg[4+i] && m_act[i], m_cfg[0]);
            en[i] = lvl(m_run && m_cfg[7+i] && !m_act[i], m_cfg[1]);
        end
        et = lvl(m_run && m_cfg[2] && m_cfg[3] && m_tog, m_cfg[0]);
        chk("R1 count", count, m_cnt);
        chk("R2 running", running, m_run);
        chk("R3 R5 R7 R8 pos", pos, ep);
        chk("R4 R7 R8 neg", neg, en);
        chk("R6 tog", tog, et);
    endtask

    task automatic step(bit c, bit w, bit [2:0] a, bit [W-1:0] d);
        bit old_run;
        bit wrap;
        @(negedge clk);
        ce = c; we = w; addr = a; data = d;
        @(posedge clk);
        old_run = m_run;
        wrap = old_run && c && (m_cnt == m_len);
        if (!old_run) begin
            m_cnt = 0; m_act = 3'b111; m_tog = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (wrap) m_act[i] = (m_cmp[i] == m_len) ? !m_act[i] : 1'b1;
                else if (c && m_cnt == m_cmp[i]) m_act[i] = 1'b0;
            end
            if (wrap) m_tog = !m_tog;
            if (wrap) m_cnt = 0;
            else if (c) m_cnt = m_cnt + 1'b1;
        end
        if (w) begin
            if (a == 0) m_run = d[0];
            else if (!old_run) begin
                case (a)
                    3'd1: m_cfg = d[9:0];
                    3'd2: m_len = d;
                    3'd3, 3'd4, 3'd5: m_cmp[a-3] = d;
                    default: ;
                endcase
            end
        end
        #2;
        compare_all();
    endtask

    task automatic setup(bit [9:0] cf, bit [W-1:0] ln, bit [W-1:0] c0,
                         bit [W-1:0] c1, bit [W-1:0] c2);
        step(0, 1, 0, 0);
        step(0, 1, 1, W'(cf));
        step(0, 1, 2, ln);
        step(0, 1, 3, c0);
        step(0, 1, 4, c1);
        step(0, 1, 5, c2);
        step(0, 1, 0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_run = 0; m_cfg = 0; m_len = 0; m_cnt = 0; m_act = 3'b111; m_tog = 0;
        for (int i = 0; i < 3; i++) m_cmp[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R9 R7 reset state: halted, polarity 0 -> every pin idles high
        chk("R9 reset pos", pos, 3'b111);
        chk("R9 reset neg", neg, 3'b111);
        chk("R9 reset tog", tog, 1);
        chk("R1 reset count", count, 0);

        // directed: duty pulses plus R5 toggle phase (cmp == len)
        setup(10'h3FF, 4, 1, 2, 4);
        repeat (30) step(1, 0, 0, 0);
        // R2: length and compare writes while running are ignored
        step(1, 1, 2, 9);
        step(1, 1, 3, 0);
        repeat (12) step(1, 0, 0, 0);
        chk("R2 length locked", count <= 4, 1);
        // R9: stop returns to idle
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        chk("R9 halted count", count, 0);
        chk("R9 halted pos", pos, 3'b000);

        // corner: length 0 (wrap every enable) and compare 0
        setup(10'h3F7, 0, 0, 0, 0);
        repeat (10) step(1, 0, 0, 0);
        setup(10'h3FE, 5, 0, 5, 3);
        repeat (20) step(($urandom % 2) == 0, 0, 0, 0);
        // R8: all pins disabled, positive level 1 -> pins stay at 0
        setup(10'h001, 3, 1, 2, 3);
        repeat (8) step(1, 0, 0, 0);
        chk("R8 disabled pos", pos, 3'b000);

        // random rounds
        for (int r = 0; r < 40; r++) begin
            bit [W-1:0] ln;
            ln = W'($urandom % 16);
            setup(10'($urandom), ln, W'($urandom % (ln + 1)),
                  W'($urandom % (ln + 1)), W'($urandom % (ln + 1)));
            for (int k = 0; k < 60; k++) begin
                if ($urandom % 10 == 0)
                    step(($urandom % 10) < 7, 1, 3'(1 + $urandom % 5), W'($urandom));
                else
                    step(($urandom % 10) < 7, 0, 0, 0);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule